// File: doc/BRIEF.md
# PCM Channel Playback Sequencer

This block runs one audio sample channel of a sound controller. Software writes a control byte (run and hold bits, playback or record direction, linear or compressed coding, rate code, left and right routing) and a format byte (sample width code, FIFO level code, interrupt mask). A shared prescaler outside the block supplies a base tick. Each running channel divides that tick by a per-channel divider picked from the rate code. At the end of every channel period it fetches one sample from a nibble FIFO.

Linear samples of 4, 8, 12 or 16 bits are sign-aligned into a 12-bit signed output. Compressed samples are one 4-bit code, handed to an external decoder, and the decoder's reply becomes the output. The output word is held until the next sample arrives. The routing enables tell the mixer whether to add it to the left and/or right sum. One cycle after each period end, the channel compares the FIFO free space with a programmed level and sets a sticky request flag. The interrupt line is that flag gated by a mask bit.

The FIFO read side is a valid/ready stream. The channel is the sink, and it raises `fifo_ready` for exactly one cycle per playback period. A transfer happens only when `fifo_valid` is high in that cycle, and the FIFO then pops `fifo_nibs` nibbles. If `fifo_valid` is low (FIFO empty), the channel does not wait: it uses all-zero data for that period and applies no back-pressure beyond the single ready cycle. Dropping the hold bit from 1 to 0 by a register write restarts the channel.

Top module: `pcm_seq_chan`

## Requirements
- R1: The channel fetches nothing and requests no decode unless control bit 0 (run) is 1 and control bit 7 (hold) is 0.
- R2: A running channel fetches on the first base tick after a restart and then on every D-th base tick. D comes from the list 1, 2, 4, 6, 8, indexed by control bits [4:3] plus 1 when control bit 2 is 0 (compressed coding).
- R3: During a fetch, `fifo_nibs` gives the nibble count. When control bit 2 is 1, format bits [6:5] map 0→2, 1→3, 2→4 and 3→1. When control bit 2 is 0 the count is always 1.
- R4: `fifo_data` is right-aligned with the first nibble most significant. In linear mode `smp_out`, from the cycle after the fetch, holds the sample sign-aligned to 12 bits: a 4-bit sample shifted left 8, an 8-bit sample left 4, a 12-bit sample unchanged, a 16-bit sample's top 12 bits. Data is taken as zero when `fifo_valid` is 0. `smp_out` changes only on a fetch, a decoder reply or a restart.
- R5: In compressed mode a fetch raises `dec_req` with `dec_code` = `fifo_data[3:0]` (0 if `fifo_valid` is 0). The next `dec_vld` loads `dec_sample` into `smp_out`.
- R6: `pan_l` = control bit 5 AND control bit 1, and `pan_r` = control bit 6 AND control bit 1.
- R7: One cycle after each period end, `stat_flag` is set when playback (control bit 1 = 1) and `fifo_free` > T, or when record and `fifo_free` < T. T = (format bits [4:2] + 1) × 16. The flag stays set until `stat_clr`.
- R8: `irq` is high exactly when `stat_flag` is 1 and format bit 1 is 0.
- R9: A write to control that changes bit 7 from 1 to 0 restarts the channel. In the next cycle `fifo_flush` and `adpcm_clr` pulse, `smp_out` is 0 and the rate counter is reloaded to fetch on the next tick.
- R10: After reset, control is 0x80, format is 0, and `smp_out`, `stat_flag`, `irq`, `pan_l` and `pan_r` are 0.
- R11: In record mode (control bit 1 = 0), `fifo_ready` and `dec_req` stay low and `smp_out` is not updated, while the period counter still runs and drives R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_tick | input | 1 | One-cycle base sample tick from the shared prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = control byte, 1 = format byte |
| wr_data | input | 8 | Register write data |
| stat_clr | input | 1 | Clears the request flag |
| fifo_valid | input | 1 | FIFO has data (stream valid) |
| fifo_ready | output | 1 | Fetch strobe (stream ready), one cycle per period |
| fifo_nibs | output | 3 | Nibbles to pop on this fetch |
| fifo_data | input | 16 | Right-aligned FIFO read data |
| fifo_free | input | 8 | FIFO free space in bytes |
| fifo_flush | output | 1 | Empties the FIFO and clears its nibble phases |
| dec_req | output | 1 | Compressed code valid for the decoder |
| dec_code | output | 4 | Compressed 4-bit code |
| dec_vld | input | 1 | Decoder reply valid |
| dec_sample | input | 12 | Decoded 12-bit sample |
| adpcm_clr | output | 1 | Clears decoder step index and accumulator |
| smp_out | output | 12 | Held signed 12-bit sample |
| pan_l | output | 1 | Add sample to left sum |
| pan_r | output | 1 | Add sample to right sum |
| stat_flag | output | 1 | Sticky FIFO-level request flag |
| irq | output | 1 | Masked interrupt |

## Verification
On every cycle the assertions check that no fetch or decode request appears while the channel is held or idle, or in record mode. They also check that fetches fall only on base ticks and in compressed mode move one nibble. Further per-cycle checks cover the spacing between fetches against the current divider, the flag staying set until cleared, the output word staying stable between its update events, and the restart pulses. The bench's scenarios show the values themselves: the mapping of each rate code and coding mode to its divider, the alignment of each sample width, the decoder reply reaching the output, the level comparison in both directions and the masked interrupt, all against bench-computed expectations over random configurations.

// File: rtl/pcm_seq_pkg.sv
package pcm_seq_pkg;

  localparam int REG_W   = 8;
  localparam int MAX_DIV = 8;
  localparam int CNT_W   = $clog2(MAX_DIV + 1);

  // control byte, MSB first
  typedef struct packed {
    logic       hold;
    logic       pan_r;
    logic       pan_l;
    logic [1:0] rate;
    logic       lin;
    logic       play;
    logic       start;
  } ctrl_t;

  // format byte, MSB first
  typedef struct packed {
    logic       spare_hi;
    logic [1:0] width;
    logic [2:0] level;
    logic       mask;
    logic       spare_lo;
  } fmt_t;

  localparam ctrl_t CTRL_RST = '{hold: 1'b1, default: '0};

  // period length in base ticks: 1, 2, 4, 6, 8
  function automatic logic [CNT_W-1:0] rate_div(input logic [2:0] idx);
    logic [CNT_W-1:0] r;
    if (idx == 3'd0) r = CNT_W'(1);
    else             r = CNT_W'({idx, 1'b0});
    return r;
  endfunction

  // nibbles per sample; top width code means one nibble
  function automatic logic [2:0] nib_count(input logic lin, input logic [1:0] w);
    logic [2:0] n;
    if (!lin) n = 3'd1;
    else begin
      case (w)
        2'd0:    n = 3'd2;
        2'd1:    n = 3'd3;
        2'd2:    n = 3'd4;
        default: n = 3'd1;
      endcase
    end
    return n;
  endfunction

endpackage

// File: rtl/pcm_seq_regs.sv
module pcm_seq_regs
  import pcm_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  output ctrl_t            ctrl_q,
  output fmt_t             fmt_q,
  output logic             rst_fall
);

  ctrl_t ctrl_new;
  logic  ctrl_wr;

  assign ctrl_new = ctrl_t'(wr_data);
  assign ctrl_wr  = wr_en && !wr_sel;
  assign rst_fall = ctrl_wr && ctrl_q.hold && !ctrl_new.hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      fmt_q  <= '0;
    end else if (wr_en) begin
      if (wr_sel) fmt_q  <= fmt_t'(wr_data);
      else        ctrl_q <= ctrl_new;
    end
  end

endmodule

// File: rtl/pcm_seq_rate.sv
module pcm_seq_rate
  import pcm_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             restart,
  input  logic [CNT_W-1:0] div,
  output logic             slot
);

  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign last = (cnt_q <= CNT_W'(1));
  assign slot = tick && run && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= CNT_W'(1);
    else if (restart)      cnt_q <= CNT_W'(1);
    else if (tick && run) begin
      if (last) cnt_q <= div;
      else      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

endmodule

// File: rtl/pcm_seq_align.sv
module pcm_seq_align #(
  parameter int DATA_W = 16,
  parameter int NIB_W  = 4,
  parameter int SMP_W  = 12
) (
  input  logic [DATA_W-1:0] data,
  input  logic [2:0]        nibs,
  output logic [SMP_W-1:0]  smp
);

  localparam int N_NIB = DATA_W / NIB_W;

  logic [SMP_W-1:0] cand [N_NIB];

  // left-justify g nibbles, keep the top SMP_W bits
  for (genvar g = 1; g <= N_NIB; g++) begin : g_width
    localparam int SH = DATA_W - g * NIB_W;
    logic [DATA_W-1:0] lj;
    assign lj          = data << SH;
    assign cand[g - 1] = lj[DATA_W-1 -: SMP_W];
  end

  always_comb begin
    smp = '0;
    for (int i = 0; i < N_NIB; i++) begin
      if (int'(nibs) == i + 1) smp = cand[i];
    end
  end

endmodule

// File: rtl/pcm_seq_status.sv
module pcm_seq_status #(
  parameter int FREE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot,
  input  logic              play,
  input  logic              restart,
  input  logic [2:0]        level,
  input  logic              mask,
  input  logic [FREE_W-1:0] free,
  input  logic              clr,
  output logic              flag,
  output logic              irq
);

  localparam int THR_W = FREE_W + 2;

  logic             pend_q;
  logic             pend_play_q;
  logic [THR_W-1:0] thr;
  logic [THR_W-1:0] free_x;
  logic             hit;

  assign thr    = THR_W'({({1'b0, level} + 4'd1), 4'b0000});
  assign free_x = THR_W'(free);
  assign hit    = pend_q && (pend_play_q ? (free_x > thr) : (free_x < thr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_play_q <= 1'b0;
    end else begin
      pend_q      <= slot && !restart;
      pend_play_q <= play;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  assign irq = flag && !mask;

endmodule

// File: rtl/pcm_seq_chan.sv
module pcm_seq_chan #(
  parameter int DATA_W = 16,
  parameter int NIB_W  = 4,
  parameter int SMP_W  = 12,
  parameter int FREE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_tick,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [7:0]        wr_data,
  input  logic              stat_clr,
  input  logic              fifo_valid,
  output logic              fifo_ready,
  output logic [2:0]        fifo_nibs,
  input  logic [DATA_W-1:0] fifo_data,
  input  logic [FREE_W-1:0] fifo_free,
  output logic              fifo_flush,
  output logic              dec_req,
  output logic [NIB_W-1:0]  dec_code,
  input  logic              dec_vld,
  input  logic [SMP_W-1:0]  dec_sample,
  output logic              adpcm_clr,
  output logic [SMP_W-1:0]  smp_out,
  output logic              pan_l,
  output logic              pan_r,
  output logic              stat_flag,
  output logic              irq
);
  import pcm_seq_pkg::*;

  ctrl_t            ctrl_q;
  fmt_t             fmt_q;
  logic             rst_fall;
  logic             active;
  logic [2:0]       rate_idx;
  logic [CNT_W-1:0] cur_div;
  logic [2:0]       cur_nibs;
  logic             slot;
  logic             fetch;
  logic [DATA_W-1:0] data_eff;
  logic [SMP_W-1:0] pcm_smp;
  logic             dec_wait_q;

  pcm_seq_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .ctrl_q   (ctrl_q),
    .fmt_q    (fmt_q),
    .rst_fall (rst_fall)
  );

  assign active   = ctrl_q.start && !ctrl_q.hold;
  assign rate_idx = {1'b0, ctrl_q.rate} + {2'b00, !ctrl_q.lin};
  assign cur_div  = rate_div(rate_idx);
  assign cur_nibs = nib_count(ctrl_q.lin, fmt_q.width);

  pcm_seq_rate u_rate (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (base_tick),
    .run     (active),
    .restart (rst_fall),
    .div     (cur_div),
    .slot    (slot)
  );

  // stream sink: one ready cycle per playback period
  assign fetch      = slot && ctrl_q.play;
  assign fifo_ready = fetch;
  assign fifo_nibs  = cur_nibs;
  assign data_eff   = fifo_valid ? fifo_data : '0;

  pcm_seq_align #(
    .DATA_W (DATA_W),
    .NIB_W  (NIB_W),
    .SMP_W  (SMP_W)
  ) u_align (
    .data (data_eff),
    .nibs (cur_nibs),
    .smp  (pcm_smp)
  );

  assign dec_req  = fetch && !ctrl_q.lin;
  assign dec_code = data_eff[NIB_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_out    <= '0;
      dec_wait_q <= 1'b0;
      fifo_flush <= 1'b0;
      adpcm_clr  <= 1'b0;
    end else begin
      fifo_flush <= rst_fall;
      adpcm_clr  <= rst_fall;
      if (rst_fall) begin
        smp_out    <= '0;
        dec_wait_q <= 1'b0;
      end else if (fetch && ctrl_q.lin) begin
        smp_out <= pcm_smp;
      end else if (dec_req) begin
        dec_wait_q <= 1'b1;
      end else if (dec_vld && dec_wait_q) begin
        smp_out    <= dec_sample;
        dec_wait_q <= 1'b0;
      end
    end
  end

  assign pan_l = ctrl_q.pan_l && ctrl_q.play;
  assign pan_r = ctrl_q.pan_r && ctrl_q.play;

  pcm_seq_status #(
    .FREE_W (FREE_W)
  ) u_stat (
    .clk     (clk),
    .rst_n   (rst_n),
    .slot    (slot),
    .play    (ctrl_q.play),
    .restart (rst_fall),
    .level   (fmt_q.level),
    .mask    (fmt_q.mask),
    .free    (fifo_free),
    .clr     (stat_clr),
    .flag    (stat_flag),
    .irq     (irq)
  );

endmodule

// File: rtl/pcm_seq_chan_chk.sv
module pcm_seq_chan_chk
  import pcm_seq_pkg::*;
#(
  parameter int SMP_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             base_tick,
  input logic             wr_en,
  input logic             wr_sel,
  input logic             stat_clr,
  input logic             fifo_ready,
  input logic [2:0]       fifo_nibs,
  input logic             fifo_flush,
  input logic             dec_req,
  input logic             dec_vld,
  input logic             adpcm_clr,
  input logic [SMP_W-1:0] smp_out,
  input logic             pan_l,
  input logic             pan_r,
  input logic             stat_flag,
  input logic             irq,
  input ctrl_t            ctrl_q,
  input logic             slot,
  input logic             rst_fall,
  input logic [CNT_W-1:0] cur_div
);

  logic             run;
  logic [CNT_W-1:0] gap_q;
  logic             seen_q;
  logic             chg_q;

  assign run = ctrl_q.start && !ctrl_q.hold;

  // ticks since last slot, to check spacing against divider
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
      chg_q  <= 1'b0;
    end else begin
      if (slot) begin
        gap_q  <= '0;
        seen_q <= 1'b1;
      end else if (base_tick && run && gap_q != {CNT_W{1'b1}}) begin
        gap_q <= gap_q + CNT_W'(1);
      end
      if ((wr_en && !wr_sel) || rst_fall) chg_q <= 1'b1;
      else if (slot)                      chg_q <= 1'b0;
    end
  end

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!fifo_ready && !dec_req));

  p_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_ready || dec_req) |-> base_tick);

  p_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (slot && seen_q && !chg_q) |-> (gap_q + CNT_W'(1) == cur_div));

  p_nib_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ready |-> (fifo_nibs >= 3'd1 && fifo_nibs <= 3'd4));

  p_code_nib_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_req |-> (fifo_ready && fifo_nibs == 3'd1));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_ready && !dec_vld && !rst_fall) |=> $stable(smp_out));

  p_pan_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pan_l || pan_r) |-> ctrl_q.play);

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_flag && !stat_clr) |=> stat_flag);

  p_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> stat_flag);

  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_fall |=> (fifo_flush && adpcm_clr && smp_out == '0));

  p_rec_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.play |-> (!fifo_ready && !dec_req));

endmodule

bind pcm_seq_chan pcm_seq_chan_chk #(.SMP_W(SMP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .base_tick  (base_tick),
  .wr_en      (wr_en),
  .wr_sel     (wr_sel),
  .stat_clr   (stat_clr),
  .fifo_ready (fifo_ready),
  .fifo_nibs  (fifo_nibs),
  .fifo_flush (fifo_flush),
  .dec_req    (dec_req),
  .dec_vld    (dec_vld),
  .adpcm_clr  (adpcm_clr),
  .smp_out    (smp_out),
  .pan_l      (pan_l),
  .pan_r      (pan_r),
  .stat_flag  (stat_flag),
  .irq        (irq),
  .ctrl_q     (ctrl_q),
  .slot       (slot),
  .rst_fall   (rst_fall),
  .cur_div    (cur_div)
);

// File: tb/pcm_seq_chan_tb_top.sv
module pcm_seq_chan_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        stat_clr = 1'b0;
  logic        fifo_valid = 1'b0;
  logic        fifo_ready;
  logic [2:0]  fifo_nibs;
  logic [15:0] fifo_data = '0;
  logic [7:0]  fifo_free = '0;
  logic        fifo_flush;
  logic        dec_req;
  logic [3:0]  dec_code;
  logic        dec_vld = 1'b0;
  logic [11:0] dec_sample = '0;
  logic        adpcm_clr;
  logic [11:0] smp_out;
  logic        pan_l;
  logic        pan_r;
  logic        stat_flag;
  logic        irq;

  int tests = 0;
  int fails = 0;
  logic        last_flush, last_aclr;
  logic [11:0] adp_val = '0;

  always #4 clk = ~clk;

  pcm_seq_chan dut_i (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .stat_clr(stat_clr),
    .fifo_valid(fifo_valid), .fifo_ready(fifo_ready), .fifo_nibs(fifo_nibs),
    .fifo_data(fifo_data), .fifo_free(fifo_free), .fifo_flush(fifo_flush),
    .dec_req(dec_req), .dec_code(dec_code), .dec_vld(dec_vld),
    .dec_sample(dec_sample), .adpcm_clr(adpcm_clr), .smp_out(smp_out),
    .pan_l(pan_l), .pan_r(pan_r), .stat_flag(stat_flag), .irq(irq)
  );

  function automatic int f_div(input logic [7:0] c);
    int idx;
    idx = int'(c[4:3]) + (c[2] ? 0 : 1);
    case (idx)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 6;
      default: return 8;
    endcase
  endfunction

  function automatic int f_nibs(input logic [7:0] c, input logic [7:0] f);
    if (!c[2]) return 1;
    case (f[6:5])
      2'd0: return 2;
      2'd1: return 3;
      2'd2: return 4;
      default: return 1;
    endcase
  endfunction

  function automatic logic [11:0] f_align(input logic [15:0] d, input int n);
    case (n)
      1: return {d[3:0], 8'h00};
      2: return {d[7:0], 4'h0};
      3: return d[11:0];
      default: return d[15:4];
    endcase
  endfunction

  function automatic logic f_flag(input logic [7:0] c, input logic [7:0] f, input int free);
    int thr;
    thr = (int'(f[4:2]) + 1) * 16;
    return c[1] ? (free > thr) : (free < thr);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    last_flush = fifo_flush;
    last_aclr  = adpcm_clr;
  endtask

  task automatic clr_flag();
    @(negedge clk); stat_clr = 1'b1;
    @(negedge clk); stat_clr = 1'b0;
  endtask

  task automatic tick(output logic got, output logic [2:0] n,
                      output logic gdec, output logic [3:0] code);
    @(negedge clk);
    base_tick = 1'b1;
    #1;
    got = fifo_ready; n = fifo_nibs; gdec = dec_req; code = dec_code;
    @(negedge clk);
    base_tick = 1'b0;
    if (gdec) begin dec_vld = 1'b1; dec_sample = adp_val; end
    @(negedge clk);
    dec_vld = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    tests++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic got, gdec;
    logic [2:0] n;
    logic [3:0] code;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk("R10 smp_out", smp_out, 0);
    chk("R10 stat_flag", stat_flag, 0);
    chk("R10 irq", irq, 0);
    chk("R10 pan", {pan_l, pan_r}, 0);

    // R1: run set but hold still set -> idle
    fifo_valid = 1'b1; fifo_data = 16'h00A5; fifo_free = 8'd0;
    wr(1'b0, 8'hA7);
    for (int k = 0; k < 3; k++) begin
      tick(got, n, gdec, code);
      chk("R1 no fetch while held", got, 0);
    end
    chk("R1 output untouched", smp_out, 0);

    // R9 restart, then 8-bit linear fetch, then restart zeroes output
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h27);
    chk("R9 flush pulse", last_flush, 1);
    chk("R9 decoder clear pulse", last_aclr, 1);
    tick(got, n, gdec, code);
    chk("R2 first tick fetch", got, 1);
    chk("R4 8-bit aligned", smp_out, 12'hA50);
    wr(1'b0, 8'hA7);
    wr(1'b0, 8'h27);
    chk("R9 output zeroed", smp_out, 0);
    chk("R9 flush on restart", last_flush, 1);

    // R7 sticky flag and clear, R8 masking
    fifo_free = 8'd100;
    clr_flag();
    tick(got, n, gdec, code);
    chk("R7 play flag set", stat_flag, 1);
    chk("R8 irq unmasked", irq, 1);
    repeat (5) @(negedge clk);
    chk("R7 flag sticky", stat_flag, 1);
    wr(1'b1, 8'h02);
    chk("R8 irq masked", irq, 0);
    clr_flag();
    chk("R7 flag cleared", stat_flag, 0);

    // R4 empty FIFO gives zero sample
    fifo_valid = 1'b0;
    wr(1'b0, 8'hA7); wr(1'b0, 8'h27);
    tick(got, n, gdec, code);
    chk("R4 empty fifo zero", smp_out, 0);

    // random configurations
    for (int it = 0; it < 80; it++) begin
      logic [7:0]  c, f;
      logic [15:0] dat;
      logic        vld;
      int          free, d, nn;
      logic        exp_got;
      logic [11:0] exp_smp;
      c = 8'($urandom); c[7] = 1'b0; c[0] = 1'b1;
      f = 8'($urandom);
      dat = 16'($urandom); vld = ($urandom % 4) != 0;
      free = int'($urandom % 129);
      fifo_data = dat; fifo_valid = vld; fifo_free = 8'(free);
      adp_val = 12'($urandom);
      d  = f_div(c);
      nn = f_nibs(c, f);
      exp_smp = 12'h000;
      wr(1'b1, f);
      wr(1'b0, c | 8'h80);
      wr(1'b0, c);
      chk("R9 restart flush", last_flush, 1);
      clr_flag();
      chk("R6 pan left", pan_l, c[5] & c[1]);
      chk("R6 pan right", pan_r, c[6] & c[1]);
      for (int k = 0; k <= 2 * d; k++) begin
        tick(got, n, gdec, code);
        exp_got = c[1] && ((k % d) == 0);
        chk("R2 fetch timing", got, exp_got);
        if (!c[1]) begin
          chk("R11 no decode in record", gdec, 0);
          chk("R11 output held in record", smp_out, 0);
        end else if (exp_got) begin
          chk("R3 nibble count", n, nn);
          if (c[2]) begin
            exp_smp = vld ? f_align(dat, nn) : 12'h000;
            chk("R4 linear sample", smp_out, exp_smp);
          end else begin
            chk("R5 decode request", gdec, 1);
            chk("R5 code", code, vld ? dat[3:0] : 4'h0);
            chk("R5 decoded sample", smp_out, adp_val);
          end
        end
        if (k == 0) begin
          chk("R7 level flag", stat_flag, f_flag(c, f, free));
          chk("R8 irq", irq, f_flag(c, f, free) & !f[1]);
        end
      end
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule